// File: doc/BRIEF.md
# Highest Priority Pending Interrupt Selector

This block reduces the per-interrupt state of an interrupt controller to one best candidate per processor core. Every interrupt carries a set of state bits (pending latch, trigger type, input level, enable, active, group, group modifier) and an 8-bit priority. Shared interrupts also carry a target-core index. Global enables for the three interrupt groups and a single-security-state control decide which groups may be signalled. For each core the block reports the winning interrupt ID, its priority and its group code. A priority of 0xFF means that nothing is pending for that core.

Work starts on a request and runs as a sequential scan, one 32-interrupt word per clock. A full request clears every core's result and walks all shared words and then each core's 32 private interrupts. A range request rescans a single shared word against the results already held. If that cannot prove the old winner still stands, the block falls back to a full rescan by itself. Results are published together with a one-cycle done pulse and hold between requests.

The controller moves through named states. ST_IDLE goes to ST_CLEAR on a full request, or to ST_RANGE on a range request. ST_CLEAR goes to ST_SHARED. ST_SHARED stays put until its last word and then goes to ST_PRIVATE. ST_PRIVATE stays put until its last core and then goes to ST_PUBLISH. ST_RANGE goes to ST_VERDICT. ST_VERDICT goes to ST_CLEAR when a fallback is needed and to ST_PUBLISH otherwise. ST_PUBLISH returns to ST_IDLE.

Top module: `hppi_selector`

## Requirements
- R1: An interrupt is pending when its latch bit is 1, or when its trigger bit is 0 (level) and its level input is 1. With the trigger bit at 1 (edge), the level input alone does not make it pending.
- R2: A pending interrupt is eligible only with its enable bit at 1 and its active bit at 0.
- R3: The group check passes in three cases. Group bit 1 needs the non-secure group 1 enable. Group bit 0 with modifier 1 needs the secure group 1 enable. Group bit 0 with modifier 0 needs the group 0 enable. The reported group code is 2 for group bit 1, 1 for group bit 0 with modifier 1, and 0 otherwise.
- R4: While the single-security-state control is 1, every group modifier bit is taken as 0, both for eligibility and for the reported group code.
- R5: Private interrupts of a core have IDs 0 to 31. Shared interrupt n has ID 32+n. The lowest priority value wins, and among equal priorities the lowest ID wins. An interrupt at priority 0xFF is never reported.
- R6: A shared interrupt competes only for the core whose index equals its target field. A target value of NUM_CORES or above reaches no core.
- R7: When a core has no winner, or after reset, its result is priority 0xFF, ID 0 and group code 0. done and busy are 0 after reset.
- R8: busy is 1 while a scan runs. A full request accepted in idle raises done for exactly one cycle, NW+NUM_CORES+3 rising edges after the edge that samples the request, where NW = NUM_SHARED/32.
- R9: The published results change only in the cycle where done is 1.
- R10: A range request rescans only shared word range_word against the held results. When no fallback is needed, done follows 4 edges after the request edge.
- R11: A range scan triggers a full rescan when the old winner of some core lies in the rescanned word, has a priority other than 0xFF, and no eligible interrupt in the word ties or beats it under the R5 order. done then follows NW+NUM_CORES+5 edges after the request edge.
- R12: Requests while busy are ignored. A full and a range request in the same idle cycle start a full scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_full | input | 1 | Start a full rescan |
| req_range | input | 1 | Start a rescan of one shared word |
| range_word | input | WW | Shared word index for a range request |
| ctl_en_g0 | input | 1 | Group 0 enable |
| ctl_en_g1s | input | 1 | Secure group 1 enable |
| ctl_en_g1ns | input | 1 | Non-secure group 1 enable |
| ctl_one_sec | input | 1 | Single-security-state control |
| sh_latch | input | NUM_SHARED | Shared pending latches |
| sh_edge | input | NUM_SHARED | Shared trigger type, 1 = edge |
| sh_level | input | NUM_SHARED | Shared input levels |
| sh_enable | input | NUM_SHARED | Shared enables |
| sh_active | input | NUM_SHARED | Shared active bits |
| sh_group | input | NUM_SHARED | Shared group bits |
| sh_gmod | input | NUM_SHARED | Shared group modifiers |
| sh_prio | input | NUM_SHARED*8 | Shared priorities |
| sh_target | input | NUM_SHARED*TW | Shared target core index |
| pv_latch | input | NUM_CORES*32 | Private pending latches |
| pv_edge | input | NUM_CORES*32 | Private trigger type |
| pv_level | input | NUM_CORES*32 | Private input levels |
| pv_enable | input | NUM_CORES*32 | Private enables |
| pv_active | input | NUM_CORES*32 | Private active bits |
| pv_group | input | NUM_CORES*32 | Private group bits |
| pv_gmod | input | NUM_CORES*32 | Private group modifiers |
| pv_prio | input | NUM_CORES*256 | Private priorities |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| best_id | output | NUM_CORES*IDW | Winning ID per core |
| best_prio | output | NUM_CORES*8 | Winning priority per core, 0xFF = none |
| best_grp | output | NUM_CORES*2 | Winning group code per core |

## Verification
The bench builds the block with NUM_CORES=2 and NUM_SHARED=64. That gives two shared words, a one-bit range index and a two-bit target field in which codes 2 and 3 name no core, so the R6 unrouted case comes up often under random targets. Priorities are drawn from a small range with occasional 0xFF, so ties between shared and private IDs and across words are frequent. With two shared words, a range rescan can hit the word that holds the old winner and can also miss it, so both the 4-edge path and the 9-edge fallback path are exercised.

// File: rtl/hppi_pkg.sv
package hppi_pkg;

    localparam int WORD_BITS = 32;
    localparam int PRIO_W    = 8;
    localparam logic [PRIO_W-1:0] PRIO_NONE = 8'hFF;

    typedef enum logic [1:0] {
        GRP_SEC0  = 2'd0,
        GRP_SEC1  = 2'd1,
        GRP_NSEC1 = 2'd2
    } grp_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_SHARED,
        ST_PRIVATE,
        ST_RANGE,
        ST_VERDICT,
        ST_PUBLISH
    } scan_state_e;

    // Candidate takes precedence over the held one: lower value, or equal value and ID not above.
    function automatic logic beats(input logic [PRIO_W-1:0] cand_p, input logic [15:0] cand_id,
                                   input logic [PRIO_W-1:0] held_p, input logic [15:0] held_id);
        return (cand_p < held_p) || ((cand_p == held_p) && (cand_id <= held_id));
    endfunction

endpackage

// File: rtl/hppi_elig_word.sv
module hppi_elig_word
    import hppi_pkg::*;
#(
    parameter int W = WORD_BITS
) (
    input  logic [W-1:0]   latch_i,
    input  logic [W-1:0]   trig_i,
    input  logic [W-1:0]   level_i,
    input  logic [W-1:0]   enable_i,
    input  logic [W-1:0]   active_i,
    input  logic [W-1:0]   group_i,
    input  logic [W-1:0]   gmod_i,
    input  logic           en_g0_i,
    input  logic           en_g1s_i,
    input  logic           en_g1ns_i,
    input  logic           one_sec_i,
    output logic [W-1:0]   elig_o,
    output logic [2*W-1:0] grp_o
);

    logic [W-1:0] pend;
    logic [W-1:0] mod_eff;
    logic [W-1:0] gmask;

    // R1: latch, or level-sensitive with input high
    assign pend    = latch_i | (~trig_i & level_i);
    // R4: modifiers forced to zero in single-security mode
    assign mod_eff = one_sec_i ? '0 : gmod_i;
    // R3: group gate
    assign gmask   = ({W{en_g1ns_i}} & group_i)
                   | ({W{en_g1s_i}}  & ~group_i & mod_eff)
                   | ({W{en_g0_i}}   & ~group_i & ~mod_eff);
    // R2
    assign elig_o  = pend & enable_i & ~active_i & gmask;

    for (genvar gi = 0; gi < W; gi++) begin : g_code
        assign grp_o[2*gi +: 2] = group_i[gi] ? GRP_NSEC1 : (mod_eff[gi] ? GRP_SEC1 : GRP_SEC0);
    end

endmodule

// File: rtl/hppi_word_pick.sv
module hppi_word_pick
    import hppi_pkg::*;
#(
    parameter int W  = WORD_BITS,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]        mask_i,
    input  logic [PRIO_W*W-1:0] prio_i,
    output logic                found_o,
    output logic [IW-1:0]       idx_o,
    output logic [PRIO_W-1:0]   prio_o
);

    // Descending walk with <= leaves the lowest index among equal priorities (R5).
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        prio_o  = PRIO_NONE;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask_i[i] && (prio_i[PRIO_W*i +: PRIO_W] != PRIO_NONE)
                && (prio_i[PRIO_W*i +: PRIO_W] <= prio_o)) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
                prio_o  = prio_i[PRIO_W*i +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/hppi_selector.sv
module hppi_selector
    import hppi_pkg::*;
#(
    parameter int  NUM_CORES  = 2,
    parameter int  NUM_SHARED = 64,
    localparam int NW  = NUM_SHARED / WORD_BITS,
    localparam int WW  = (NW > 1) ? $clog2(NW) : 1,
    localparam int CW  = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int TW  = CW + 1,
    localparam int IDW = $clog2(WORD_BITS + NUM_SHARED),
    localparam int PV  = NUM_CORES * WORD_BITS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_full,
    input  logic                          req_range,
    input  logic [WW-1:0]                 range_word,
    input  logic                          ctl_en_g0,
    input  logic                          ctl_en_g1s,
    input  logic                          ctl_en_g1ns,
    input  logic                          ctl_one_sec,
    input  logic [NUM_SHARED-1:0]         sh_latch,
    input  logic [NUM_SHARED-1:0]         sh_edge,
    input  logic [NUM_SHARED-1:0]         sh_level,
    input  logic [NUM_SHARED-1:0]         sh_enable,
    input  logic [NUM_SHARED-1:0]         sh_active,
    input  logic [NUM_SHARED-1:0]         sh_group,
    input  logic [NUM_SHARED-1:0]         sh_gmod,
    input  logic [NUM_SHARED*PRIO_W-1:0]  sh_prio,
    input  logic [NUM_SHARED*TW-1:0]      sh_target,
    input  logic [PV-1:0]                 pv_latch,
    input  logic [PV-1:0]                 pv_edge,
    input  logic [PV-1:0]                 pv_level,
    input  logic [PV-1:0]                 pv_enable,
    input  logic [PV-1:0]                 pv_active,
    input  logic [PV-1:0]                 pv_group,
    input  logic [PV-1:0]                 pv_gmod,
    input  logic [PV*PRIO_W-1:0]          pv_prio,
    output logic                          busy,
    output logic                          done,
    output logic [NUM_CORES*IDW-1:0]      best_id,
    output logic [NUM_CORES*PRIO_W-1:0]   best_prio,
    output logic [NUM_CORES*2-1:0]        best_grp
);

    localparam int WP = WORD_BITS * PRIO_W;
    localparam int WT = WORD_BITS * TW;

    scan_state_e state_q, state_d;

    logic [WW-1:0]        word_q;
    logic [WW-1:0]        rword_q;
    logic [CW-1:0]        core_q;
    logic                 done_q;
    logic [NUM_CORES-1:0] need_full;

    logic word_last, core_last, priv_phase, scan_phase;
    logic [WW-1:0] sel_word;

    assign word_last  = (word_q == WW'(NW - 1));
    assign core_last  = (core_q == CW'(NUM_CORES - 1));
    assign priv_phase = (state_q == ST_PRIVATE);
    assign scan_phase = (state_q == ST_SHARED) || (state_q == ST_PRIVATE) || (state_q == ST_RANGE);
    assign sel_word   = (state_q == ST_RANGE) ? rword_q : word_q;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_full)       state_d = ST_CLEAR;   // R12 full wins
                else if (req_range) state_d = ST_RANGE;
            end
            ST_CLEAR:   state_d = ST_SHARED;
            ST_SHARED:  if (word_last) state_d = ST_PRIVATE;
            ST_PRIVATE: if (core_last) state_d = ST_PUBLISH;
            ST_RANGE:   state_d = ST_VERDICT;
            ST_VERDICT: state_d = (|need_full) ? ST_CLEAR : ST_PUBLISH; // R11
            ST_PUBLISH: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // ---------------- sequencing registers and done ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            core_q  <= '0;
            rword_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (state_q == ST_PUBLISH);
            unique case (state_q)
                ST_IDLE:    if (req_range && !req_full) rword_q <= range_word;
                ST_CLEAR: begin
                    word_q <= '0;
                    core_q <= '0;
                end
                ST_SHARED:  word_q <= word_q + 1'b1;
                ST_PRIVATE: core_q <= core_q + 1'b1;
                default: ;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;

    // ---------------- word selection ----------------
    logic [WORD_BITS-1:0] cur_latch, cur_trig, cur_level, cur_enable, cur_active, cur_group, cur_gmod;
    logic [WP-1:0]        cur_prio;
    logic [WT-1:0]        cur_tgt;
    logic [IDW-1:0]       base_id;

    always_comb begin
        if (priv_phase) begin
            cur_latch  = pv_latch  [core_q*WORD_BITS +: WORD_BITS];
            cur_trig   = pv_edge   [core_q*WORD_BITS +: WORD_BITS];
            cur_level  = pv_level  [core_q*WORD_BITS +: WORD_BITS];
            cur_enable = pv_enable [core_q*WORD_BITS +: WORD_BITS];
            cur_active = pv_active [core_q*WORD_BITS +: WORD_BITS];
            cur_group  = pv_group  [core_q*WORD_BITS +: WORD_BITS];
            cur_gmod   = pv_gmod   [core_q*WORD_BITS +: WORD_BITS];
            cur_prio   = pv_prio   [core_q*WP +: WP];
            cur_tgt    = '0;
            base_id    = '0;
        end else begin
            cur_latch  = sh_latch  [sel_word*WORD_BITS +: WORD_BITS];
            cur_trig   = sh_edge   [sel_word*WORD_BITS +: WORD_BITS];
            cur_level  = sh_level  [sel_word*WORD_BITS +: WORD_BITS];
            cur_enable = sh_enable [sel_word*WORD_BITS +: WORD_BITS];
            cur_active = sh_active [sel_word*WORD_BITS +: WORD_BITS];
            cur_group  = sh_group  [sel_word*WORD_BITS +: WORD_BITS];
            cur_gmod   = sh_gmod   [sel_word*WORD_BITS +: WORD_BITS];
            cur_prio   = sh_prio   [sel_word*WP +: WP];
            cur_tgt    = sh_target [sel_word*WT +: WT];
            base_id    = IDW'(WORD_BITS * (int'(sel_word) + 1)); // R5 shared IDs from 32
        end
    end

    logic [WORD_BITS-1:0]   cur_elig;
    logic [2*WORD_BITS-1:0] cur_grp;

    hppi_elig_word #(.W(WORD_BITS)) u_elig (
        .latch_i   (cur_latch),
        .trig_i    (cur_trig),
        .level_i   (cur_level),
        .enable_i  (cur_enable),
        .active_i  (cur_active),
        .group_i   (cur_group),
        .gmod_i    (cur_gmod),
        .en_g0_i   (ctl_en_g0),
        .en_g1s_i  (ctl_en_g1s),
        .en_g1ns_i (ctl_en_g1ns),
        .one_sec_i (ctl_one_sec),
        .elig_o    (cur_elig),
        .grp_o     (cur_grp)
    );

    logic [IDW-1:0] rng_lo, rng_hi;
    assign rng_lo = IDW'(WORD_BITS * (int'(rword_q) + 1));
    assign rng_hi = rng_lo + IDW'(WORD_BITS - 1);

    // ---------------- per-core reduction and result registers ----------------
    for (genvar ck = 0; ck < NUM_CORES; ck++) begin : g_core
        logic [WORD_BITS-1:0]         hit;
        logic                         found;
        logic [$clog2(WORD_BITS)-1:0] idx;
        logic [PRIO_W-1:0]            cand_prio;
        logic [IDW-1:0]               cand_id;
        logic [1:0]                   cand_grp;
        logic                         take;

        logic [PRIO_W-1:0] wprio_q, oprio_q;
        logic [IDW-1:0]    wid_q,   oid_q;
        logic [1:0]        wgrp_q,  ogrp_q;
        logic              seen_q;

        // R6: routing by target field, private words belong to their core
        always_comb begin
            for (int b = 0; b < WORD_BITS; b++) begin
                hit[b] = cur_elig[b] && (priv_phase ? (core_q == CW'(ck))
                                                    : (cur_tgt[b*TW +: TW] == TW'(ck)));
            end
        end

        hppi_word_pick #(.W(WORD_BITS)) u_pick (
            .mask_i  (hit),
            .prio_i  (cur_prio),
            .found_o (found),
            .idx_o   (idx),
            .prio_o  (cand_prio)
        );

        assign cand_id  = base_id + IDW'(idx);
        assign cand_grp = cur_grp[2*int'(idx) +: 2];
        assign take     = scan_phase && found
                       && beats(cand_prio, 16'(cand_id), wprio_q, 16'(wid_q));

        // R11: held winner inside the rescanned word not confirmed
        assign need_full[ck] = !seen_q && (wprio_q != PRIO_NONE)
                            && (wid_q >= rng_lo) && (wid_q <= rng_hi);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wprio_q <= PRIO_NONE;
                wid_q   <= '0;
                wgrp_q  <= '0;
                seen_q  <= 1'b0;
                oprio_q <= PRIO_NONE;
                oid_q   <= '0;
                ogrp_q  <= '0;
            end else begin
                if (state_q == ST_IDLE) seen_q <= 1'b0;
                if (state_q == ST_CLEAR) begin
                    wprio_q <= PRIO_NONE;
                    wid_q   <= '0;
                    wgrp_q  <= '0;
                end else if (take) begin
                    wprio_q <= cand_prio;
                    wid_q   <= cand_id;
                    wgrp_q  <= cand_grp;
                    seen_q  <= 1'b1;
                end
                if (state_q == ST_PUBLISH) begin // R9
                    oprio_q <= wprio_q;
                    oid_q   <= wid_q;
                    ogrp_q  <= wgrp_q;
                end
            end
        end

        assign best_prio[ck*PRIO_W +: PRIO_W] = oprio_q;
        assign best_id  [ck*IDW +: IDW]       = oid_q;
        assign best_grp [ck*2 +: 2]           = ogrp_q;
    end

endmodule

// File: rtl/hppi_selector_chk.sv
module hppi_selector_chk
    import hppi_pkg::*;
#(
    parameter int NUM_CORES  = 2,
    parameter int NUM_SHARED = 64,
    parameter int IDW        = 7
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_full,
    input logic                        req_range,
    input logic                        busy,
    input logic                        done,
    input logic [NUM_CORES*IDW-1:0]    best_id,
    input logic [NUM_CORES*PRIO_W-1:0] best_prio,
    input logic [NUM_CORES*2-1:0]      best_grp
);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy)); // R8
    AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (!busy && (req_full || req_range)) |=> busy); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> ($stable(best_prio) && $stable(best_id) && $stable(best_grp))); // R9

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_chk
        AST_NONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (best_prio[k*PRIO_W +: PRIO_W] == PRIO_NONE) |-> ((best_id[k*IDW +: IDW] == '0) && (best_grp[k*2 +: 2] == 2'd0))); // R7
        AST_GRP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) best_grp[k*2 +: 2] != 2'd3); // R3
        AST_ID_BOUND: assert property (@(posedge clk) disable iff (!rst_n) int'(best_id[k*IDW +: IDW]) < (32 + NUM_SHARED)); // R5
    end

endmodule

bind hppi_selector hppi_selector_chk #(
    .NUM_CORES (NUM_CORES),
    .NUM_SHARED(NUM_SHARED),
    .IDW       (IDW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_full  (req_full),
    .req_range (req_range),
    .busy      (busy),
    .done      (done),
    .best_id   (best_id),
    .best_prio (best_prio),
    .best_grp  (best_grp)
);

// File: tb/hppi_selector_tb.sv
module hppi_selector_tb_top;

    localparam int NC  = 2;
    localparam int NS  = 64;
    localparam int NW  = 2;
    localparam int WW  = 1;
    localparam int TW  = 2;
    localparam int IDW = 7;
    localparam int PV  = NC * 32;
    localparam int LAT_FULL  = NW + NC + 3;
    localparam int LAT_RANGE = 4;
    localparam int LAT_FALL  = NW + NC + 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic req_full = 0, req_range = 0;
    logic [WW-1:0] range_word = '0;
    logic en_g0 = 0, en_g1s = 0, en_g1ns = 0, one_sec = 0;
    logic [NS-1:0] sh_latch = '0, sh_edge = '0, sh_level = '0, sh_enable = '0;
    logic [NS-1:0] sh_active = '0, sh_group = '0, sh_gmod = '0;
    logic [NS*8-1:0] sh_prio = '0;
    logic [NS*TW-1:0] sh_target = '0;
    logic [PV-1:0] pv_latch = '0, pv_edge = '0, pv_level = '0, pv_enable = '0;
    logic [PV-1:0] pv_active = '0, pv_group = '0, pv_gmod = '0;
    logic [PV*8-1:0] pv_prio = '0;

    logic busy, done;
    logic [NC*IDW-1:0] best_id;
    logic [NC*8-1:0]   best_prio;
    logic [NC*2-1:0]   best_grp;

    hppi_selector #(.NUM_CORES(NC), .NUM_SHARED(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_full(req_full), .req_range(req_range),
        .range_word(range_word), .ctl_en_g0(en_g0), .ctl_en_g1s(en_g1s),
        .ctl_en_g1ns(en_g1ns), .ctl_one_sec(one_sec),
        .sh_latch(sh_latch), .sh_edge(sh_edge), .sh_level(sh_level), .sh_enable(sh_enable),
        .sh_active(sh_active), .sh_group(sh_group), .sh_gmod(sh_gmod), .sh_prio(sh_prio),
        .sh_target(sh_target),
        .pv_latch(pv_latch), .pv_edge(pv_edge), .pv_level(pv_level), .pv_enable(pv_enable),
        .pv_active(pv_active), .pv_group(pv_group), .pv_gmod(pv_gmod), .pv_prio(pv_prio),
        .busy(busy), .done(done), .best_id(best_id), .best_prio(best_prio), .best_grp(best_grp)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] last_p [NC];
    int         last_id [NC];

    task automatic fail_line(input string tag, input string what, input int act, input int exp);
        errors++;
        $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    endtask

    function automatic bit elig(bit l, bit t, bit lv, bit en, bit ac, bit g, bit m);
        bit pend, mm, gok;
        pend = l | (!t & lv);
        mm   = one_sec ? 1'b0 : m;
        gok  = (g & en_g1ns) | (!g & mm & en_g1s) | (!g & !mm & en_g0);
        return pend & en & !ac & gok;
    endfunction

    function automatic logic [1:0] gcode(bit g, bit m);
        if (g) return 2'd2;
        if (m && !one_sec) return 2'd1;
        return 2'd0;
    endfunction

    function automatic bit sh_ok(int j, int k);
        return (int'(sh_target[j*TW +: TW]) == k) && (sh_prio[j*8 +: 8] != 8'hFF) &&
               elig(sh_latch[j], sh_edge[j], sh_level[j], sh_enable[j], sh_active[j], sh_group[j], sh_gmod[j]);
    endfunction

    task automatic ref_core(input int k, output logic [7:0] p, output int id, output logic [1:0] g);
        p = 8'hFF; id = 0; g = 2'd0;
        for (int i = 0; i < 32; i++) begin
            int b = k*32 + i;
            if (pv_prio[b*8 +: 8] != 8'hFF && pv_prio[b*8 +: 8] < p &&
                elig(pv_latch[b], pv_edge[b], pv_level[b], pv_enable[b], pv_active[b], pv_group[b], pv_gmod[b])) begin
                p = pv_prio[b*8 +: 8]; id = i; g = gcode(pv_group[b], pv_gmod[b]);
            end
        end
        for (int j = 0; j < NS; j++) begin
            if (sh_ok(j, k) && sh_prio[j*8 +: 8] < p) begin
                p = sh_prio[j*8 +: 8]; id = 32 + j; g = gcode(sh_group[j], sh_gmod[j]);
            end
        end
    endtask

    task automatic check_outputs(input string tag);
        for (int k = 0; k < NC; k++) begin
            logic [7:0] p; int id; logic [1:0] g;
            ref_core(k, p, id, g);
            checks++;
            if (best_prio[k*8 +: 8] !== p || int'(best_id[k*IDW +: IDW]) != id || best_grp[k*2 +: 2] !== g) begin
                errors++;
                $display("FAIL %s core%0d: actual prio=%0h id=%0d grp=%0d expected prio=%0h id=%0d grp=%0d",
                         tag, k, best_prio[k*8 +: 8], best_id[k*IDW +: IDW], best_grp[k*2 +: 2], p, id, g);
            end
            last_p[k] = p; last_id[k] = id;
        end
    endtask

    task automatic run_op(input bit f, input bit r, input int w, input int exp_lat, input string tag);
        int cnt;
        @(negedge clk);
        req_full = f; req_range = r; range_word = WW'(w);
        @(posedge clk); cnt = 1;
        @(negedge clk);
        req_full = 0; req_range = 0;
        while (!done && cnt < 60) begin
            @(posedge clk); cnt++;
            @(negedge clk);
        end
        checks++;
        if (!done || cnt != exp_lat) fail_line(tag, "done latency", done ? cnt : -1, exp_lat);
    endtask

    function automatic bit predict_fall(int w);
        for (int k = 0; k < NC; k++) begin
            if (last_p[k] != 8'hFF && last_id[k] >= 32 + 32*w && last_id[k] < 64 + 32*w) begin
                bit seen = 0;
                for (int j = 32*w; j < 32*w + 32; j++) begin
                    if (sh_ok(j, k) && (sh_prio[j*8 +: 8] < last_p[k] ||
                        (sh_prio[j*8 +: 8] == last_p[k] && 32 + j <= last_id[k]))) seen = 1;
                end
                if (!seen) return 1;
            end
        end
        return 0;
    endfunction

    function automatic logic [63:0] r64();
        return {$urandom, $urandom};
    endfunction

    task automatic rand_word(input int w);
        logic [31:0] a, b;
        a = $urandom; b = $urandom;
        sh_latch [w*32 +: 32] = a & b;
        sh_edge  [w*32 +: 32] = $urandom;
        sh_level [w*32 +: 32] = $urandom;
        sh_enable[w*32 +: 32] = a | b;
        sh_active[w*32 +: 32] = $urandom & $urandom & $urandom;
        sh_group [w*32 +: 32] = $urandom;
        sh_gmod  [w*32 +: 32] = $urandom;
        for (int j = w*32; j < w*32 + 32; j++) begin
            sh_prio[j*8 +: 8] = ($urandom % 20 == 0) ? 8'hFF : 8'($urandom % 12);
            sh_target[j*TW +: TW] = TW'($urandom);
        end
    endtask

    task automatic rand_all();
        for (int w = 0; w < NW; w++) rand_word(w);
        pv_latch = r64() & r64(); pv_edge = r64(); pv_level = r64();
        pv_enable = r64() | r64(); pv_active = r64() & r64() & r64();
        pv_group = r64(); pv_gmod = r64();
        for (int b = 0; b < PV; b++) pv_prio[b*8 +: 8] = ($urandom % 20 == 0) ? 8'hFF : 8'(4 + $urandom % 12);
        en_g0 = ($urandom % 4) != 0; en_g1s = ($urandom % 4) != 0;
        en_g1ns = ($urandom % 4) != 0; one_sec = ($urandom % 3) == 0;
    endtask

    task automatic clear_all();
        sh_latch = '0; sh_edge = '0; sh_level = '0; sh_enable = '0; sh_active = '0;
        sh_group = '0; sh_gmod = '0; sh_prio = '1; sh_target = '0;
        pv_latch = '0; pv_edge = '0; pv_level = '0; pv_enable = '0; pv_active = '0;
        pv_group = '0; pv_gmod = '0; pv_prio = '1;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int cnt;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        for (int k = 0; k < NC; k++) begin
            checks++;
            if (best_prio[k*8 +: 8] !== 8'hFF || best_id[k*IDW +: IDW] !== '0 || best_grp[k*2 +: 2] !== 2'd0)
                fail_line("R7", "reset result prio", int'(best_prio[k*8 +: 8]), 255);
        end
        checks++;
        if (done !== 1'b0 || busy !== 1'b0) fail_line("R7", "reset done/busy", int'({done, busy}), 0);

        // R7/R8 nothing eligible
        run_op(1, 0, 0, LAT_FULL, "R8 full latency");
        check_outputs("R7 empty");

        // R1 level vs edge
        en_g0 = 1; en_g1s = 1; en_g1ns = 1; one_sec = 0;
        sh_group = '1; sh_enable = '1;
        sh_edge[8] = 1; sh_level[8] = 1; sh_prio[8*8 +: 8] = 8'd3;
        sh_level[9] = 1; sh_prio[9*8 +: 8] = 8'd5;
        sh_latch[10] = 1; sh_edge[10] = 1; sh_prio[10*8 +: 8] = 8'd4; sh_target[10*TW +: TW] = 2'd1;
        run_op(1, 0, 0, LAT_FULL, "R8");
        check_outputs("R1 pending rule");

        // R2 active blocks
        sh_active[9] = 1;
        run_op(1, 0, 0, LAT_FULL, "R8");
        check_outputs("R2 active");
        sh_active[9] = 0;

        // R5 tie: private 7 vs shared 41 at same priority
        pv_enable = '1; pv_group = '1; pv_latch[7] = 1; pv_prio[7*8 +: 8] = 8'd5;
        run_op(1, 0, 0, LAT_FULL, "R8");
        check_outputs("R5 tie lowest id");
        checks++;
        if (best_id[0 +: IDW] != 7) fail_line("R5", "tie id", int'(best_id[0 +: IDW]), 7);

        // R6 unimplemented target
        clear_all();
        sh_enable[0] = 1; sh_latch[0] = 1; sh_prio[0 +: 8] = 8'd1; sh_target[0 +: TW] = 2'd3; sh_group[0] = 1;
        run_op(1, 0, 0, LAT_FULL, "R8");
        check_outputs("R6 unrouted");
        checks++;
        if (best_prio !== '1) fail_line("R6", "prio", int'(best_prio[7:0]), 255);

        // R3/R4 secure group 1 with single-security override
        sh_group[0] = 0; sh_gmod[0] = 1; sh_target[0 +: TW] = 2'd1;
        en_g0 = 0; en_g1s = 1; en_g1ns = 0; one_sec = 0;
        run_op(1, 0, 0, LAT_FULL, "R8");
        check_outputs("R3 group code");
        checks++;
        if (best_grp[3:2] !== 2'd1) fail_line("R3", "grp code", int'(best_grp[3:2]), 1);
        one_sec = 1;
        run_op(1, 0, 0, LAT_FULL, "R8");
        check_outputs("R4 modifier forced");
        en_g0 = 1;
        run_op(1, 0, 0, LAT_FULL, "R8");
        check_outputs("R4 group0 path");

        // R12 both requests together: full scan
        run_op(1, 1, 1, LAT_FULL, "R12 both");
        check_outputs("R12 both");

        // R12 request while busy ignored
        @(negedge clk); req_full = 1;
        @(posedge clk); cnt = 1;
        @(negedge clk); req_full = 0;
        @(posedge clk); cnt++;
        @(negedge clk); req_range = 1; req_full = 1;
        @(posedge clk); cnt++;
        @(negedge clk); req_range = 0; req_full = 0;
        while (!done && cnt < 60) begin @(posedge clk); cnt++; @(negedge clk); end
        checks++;
        if (cnt != LAT_FULL) fail_line("R12", "busy latency", cnt, LAT_FULL);
        @(posedge clk); @(negedge clk);
        checks++;
        if (busy !== 1'b0) fail_line("R12", "busy after done", int'(busy), 0);

        // R10 directed: winner outside rescanned word
        clear_all();
        en_g0 = 1; en_g1s = 1; en_g1ns = 1; one_sec = 0;
        sh_enable = '1; sh_group = '1;
        sh_latch[2] = 1; sh_prio[2*8 +: 8] = 8'd2;
        sh_latch[33] = 1; sh_prio[33*8 +: 8] = 8'd6;
        run_op(1, 0, 0, LAT_FULL, "R8");
        check_outputs("R10 setup");
        sh_prio[33*8 +: 8] = 8'd9;
        run_op(0, 1, 1, LAT_RANGE, "R10 range latency");
        check_outputs("R10 range");

        // R11 directed: winner in word deactivated
        sh_latch[2] = 0;
        run_op(1, 0, 0, LAT_FULL, "R8");
        check_outputs("R11 setup");
        sh_active[33] = 1;
        run_op(0, 1, 1, LAT_FALL, "R11 fallback latency");
        check_outputs("R11 fallback");

        // R9 hold between requests
        rand_all();
        repeat (6) @(negedge clk);
        for (int k = 0; k < NC; k++) begin
            checks++;
            if (best_prio[k*8 +: 8] !== last_p[k] || int'(best_id[k*IDW +: IDW]) != last_id[k])
                fail_line("R9", "held prio", int'(best_prio[k*8 +: 8]), int'(last_p[k]));
        end

        // random mix
        for (int it = 0; it < 60; it++) begin
            int w;
            bit fb;
            rand_all();
            run_op(1, 0, 0, LAT_FULL, "R8 random");
            check_outputs("R5 random full");
            w = $urandom % NW;
            if ($urandom % 2) rand_word(w);
            else begin
                for (int j = 32*w; j < 32*w + 32; j++)
                    if ($urandom % 4 == 0) sh_active[j] = 1;
            end
            fb = predict_fall(w);
            run_op(0, 1, w, fb ? LAT_FALL : LAT_RANGE, fb ? "R11 random" : "R10 random");
            check_outputs(fb ? "R11 random result" : "R10 random result");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule